// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a progressive video raster. A pixel counter runs across each line and a line counter runs across each frame. From the two counts it derives horizontal sync, vertical sync, horizontal blank, vertical blank, active video and active chroma. Each of these six outputs has its own polarity. Vertical sync and vertical blank can each start and stop part of the way into a line, through programmable pixel offsets.

Software programs the block through a plain synchronous register port with address, write data, write enable and read data. Timing, polarity and encoding writes land in shadow registers. They reach the working set only after a commit request, and only at a frame boundary, so a frame in flight is never torn. Two sticky status bits record the start of vertical blank and the start of active video. An interrupt line combines these bits with their enables.

The block has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the generator is stopped, every output sits at its inactive level with all polarity bits set (so all outputs are 0), irq is 0, the control word reads 0 and the polarity word reads 0x3F.
- R2: Control word (address 0) bit 2 runs the generator. While it runs, the pixel count steps 0 .. total_pixels-1 (address 6, bits 12:0). Then the line count steps, 0 .. total_lines-1 (address 7, bits 12:0). The frame parity toggles at each frame wrap, and frame 0 counts as even. The counters start at (0,0) in the cycle after the enabling write.
- R3: Horizontal blank is active for pixel >= active_pixels (address 5, bits 12:0). Horizontal sync is active for hs_start <= pixel < hs_end (address 8, start in 12:0, end in 28:16). Active video is active exactly when neither blank is.
- R4: Vertical blank becomes active at line active_lines (address 5, bits 28:16) once the pixel reaches vb_hstart. It stays active until line 0 reaches vb_hend (address 11, start in 12:0, end in 28:16). An offset of 0 switches at the first pixel of the line.
- R5: Vertical sync is active from (vs_start line, vs_hstart pixel) up to but not including (vs_end line, vs_hend pixel). The lines are at address 9 (start in 12:0, end in 28:16) and the pixel offsets at address 10, in the same layout.
- R6: Polarity word (address 3): vblank is bit 0, hblank bit 1, vsync bit 2, hsync bit 3, active video bit 4 and active chroma bit 5. A set bit drives that output high when active; a clear bit drives it low when active.
- R7: Encoding word (address 4) bits 9:8 select when active chroma follows active video. Code 0 selects even lines, 1 odd lines, 2 even lines of even frames only, and 3 odd lines of even frames only.
- R8: Writes to addresses 3..11 change only the shadow copy, and reads return the shadow. Writing control bit 1 requests a commit. The commit takes effect when the frame wraps, or on the next cycle if the generator is stopped.
- R9: Writing 0 to the control word stops the generator. Every output goes to its inactive level in the next cycle, and the counters are held at (0,0).
- R10: Status word (address 1): bit 12 is set on a rising edge of internal vertical blank and bit 13 on a rising edge of internal active video. Writing 1 to a bit clears it. A new rising edge in the same cycle wins over the clear.
- R11: irq is high while any status bit is set together with the matching enable bit, at the same position in the enable word (address 2).
- R12: Reads return the addressed word one cycle after the address is presented. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| active_video | output | 1 | Active picture area |
| active_chroma | output | 1 | Active picture on chroma-carrying lines |
| irq | output | 1 | Interrupt request |

## Verification
The bench keeps its own reference of the counters and the working set, and compares all six outputs and irq on every cycle while it drives these cases:
- A mid-frame commit of a new line length. A design that applies it at once would show a shortened line in the old frame and drift out of step.
- Non-zero horizontal offsets for vertical blank and vertical sync. A design that compares lines only would switch these signals at pixel 0.
- All four chroma parity codes over several frames. Confusing frame parity with line parity would blank chroma in the wrong frames.
- The stop write followed by re-enabling. Outputs left at the active level, or counters that resume mid-frame, would show up here.
- Write-1-to-clear of a single status bit. Clearing the whole word would drop the other pending event and the interrupt with it.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int CW = 13;
  localparam int DW = 32;
  localparam int AW = 4;

  localparam logic [AW-1:0] ADDR_CTRL   = 4'd0;
  localparam logic [AW-1:0] ADDR_STATUS = 4'd1;
  localparam logic [AW-1:0] ADDR_IEN    = 4'd2;
  localparam logic [AW-1:0] ADDR_POL    = 4'd3;
  localparam logic [AW-1:0] ADDR_ENC    = 4'd4;
  localparam logic [AW-1:0] ADDR_ACT    = 4'd5;
  localparam logic [AW-1:0] ADDR_HTOT   = 4'd6;
  localparam logic [AW-1:0] ADDR_VTOT   = 4'd7;
  localparam logic [AW-1:0] ADDR_HSYNC  = 4'd8;
  localparam logic [AW-1:0] ADDR_VSLN   = 4'd9;
  localparam logic [AW-1:0] ADDR_VSOFF  = 4'd10;
  localparam logic [AW-1:0] ADDR_VBOFF  = 4'd11;

  localparam int SH_BASE = 3;
  localparam int SH_NUM  = 9;

  localparam int HI_LSB = 16;
  localparam int CTRL_RUN = 2;
  localparam int CTRL_COMMIT = 1;
  localparam int ST_VB = 12;
  localparam int ST_AV = 13;
  localparam int PAR_LSB = 8;

  typedef struct packed {
    logic [CW-1:0] act_px;
    logic [CW-1:0] act_ln;
    logic [CW-1:0] hs_s;
    logic [CW-1:0] hs_e;
    logic [CW-1:0] vs_s;
    logic [CW-1:0] vs_e;
    logic [CW-1:0] vsh_s;
    logic [CW-1:0] vsh_e;
    logic [CW-1:0] vbh_s;
    logic [CW-1:0] vbh_e;
    logic [5:0]    pol;
    logic [1:0]    par;
  } shape_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          frame_wrap,
  input  logic          vb_rise,
  input  logic          av_rise,
  output logic [DW-1:0] rd_data,
  output logic          gen_en,
  output logic [CW-1:0] htot,
  output logic [CW-1:0] vtot,
  output shape_t        shape,
  output logic          irq
);
  localparam logic [DW-1:0] POL_RST = 32'h0000_003F;

  logic [DW-1:0] sh_q [SH_NUM];
  logic          pend_q;
  logic [1:0]    st_q;
  logic [1:0]    ien_q;
  logic          commit_req;
  logic          apply;
  logic [1:0]    clr;
  logic [1:0]    set;
  shape_t        shape_nx;

  function automatic logic [CW-1:0] lo_f(input logic [DW-1:0] w);
    return w[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] hi_f(input logic [DW-1:0] w);
    return w[HI_LSB+CW-1:HI_LSB];
  endfunction

  assign commit_req = wr_en && (addr == ADDR_CTRL) && wr_data[CTRL_COMMIT];
  assign apply      = pend_q && (!gen_en || frame_wrap);
  assign clr        = (wr_en && addr == ADDR_STATUS) ? wr_data[ST_AV:ST_VB] : 2'b00;
  assign set        = {av_rise, vb_rise};

  always_comb begin
    shape_nx.pol    = sh_q[ADDR_POL - SH_BASE][5:0];
    shape_nx.par    = sh_q[ADDR_ENC - SH_BASE][PAR_LSB+1:PAR_LSB];
    shape_nx.act_px = lo_f(sh_q[ADDR_ACT - SH_BASE]);
    shape_nx.act_ln = hi_f(sh_q[ADDR_ACT - SH_BASE]);
    shape_nx.hs_s   = lo_f(sh_q[ADDR_HSYNC - SH_BASE]);
    shape_nx.hs_e   = hi_f(sh_q[ADDR_HSYNC - SH_BASE]);
    shape_nx.vs_s   = lo_f(sh_q[ADDR_VSLN - SH_BASE]);
    shape_nx.vs_e   = hi_f(sh_q[ADDR_VSLN - SH_BASE]);
    shape_nx.vsh_s  = lo_f(sh_q[ADDR_VSOFF - SH_BASE]);
    shape_nx.vsh_e  = hi_f(sh_q[ADDR_VSOFF - SH_BASE]);
    shape_nx.vbh_s  = lo_f(sh_q[ADDR_VBOFF - SH_BASE]);
    shape_nx.vbh_e  = hi_f(sh_q[ADDR_VBOFF - SH_BASE]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SH_NUM; i++)
        sh_q[i] <= (i == int'(ADDR_POL) - SH_BASE) ? POL_RST : '0;
    end else if (wr_en && addr >= SH_BASE && addr < SH_BASE + SH_NUM) begin
      sh_q[addr - SH_BASE] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en <= 1'b0;
      pend_q <= 1'b0;
      st_q   <= 2'b00;
      ien_q  <= 2'b00;
      htot   <= '0;
      vtot   <= '0;
      shape  <= '{pol: 6'h3F, par: 2'd0, default: '0};
    end else begin
      if (apply) begin
        shape <= shape_nx;
        htot  <= lo_f(sh_q[ADDR_HTOT - SH_BASE]);
        vtot  <= lo_f(sh_q[ADDR_VTOT - SH_BASE]);
      end
      pend_q <= (pend_q && !apply) || commit_req;
      st_q   <= (st_q & ~clr) | set;
      if (wr_en && addr == ADDR_CTRL) gen_en <= wr_data[CTRL_RUN];
      if (wr_en && addr == ADDR_IEN)  ien_q  <= wr_data[ST_AV:ST_VB];
    end
  end

  assign irq = |(st_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      if (addr == ADDR_CTRL) rd_data[CTRL_RUN] <= gen_en;
      else if (addr == ADDR_STATUS) rd_data[ST_AV:ST_VB] <= st_q;
      else if (addr == ADDR_IEN) rd_data[ST_AV:ST_VB] <= ien_q;
      else if (addr >= SH_BASE && addr < SH_BASE + SH_NUM) rd_data <= sh_q[addr - SH_BASE];
    end
  end

  AST_COMMIT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(htot) |-> $past(!gen_en || frame_wrap)); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q[0] && !(wr_en && addr == ADDR_STATUS && wr_data[ST_VB]) |=> st_q[0]); // R10
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    av_rise |=> st_q[1]); // R10
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic [CW-1:0] htot,
  input  logic [CW-1:0] vtot,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic          fpar,
  output logic          frame_wrap
);
  logic h_last;
  logic v_last;

  assign h_last     = ({1'b0, hcnt} + (CW+1)'(1)) >= {1'b0, htot};
  assign v_last     = ({1'b0, vcnt} + (CW+1)'(1)) >= {1'b0, vtot};
  assign frame_wrap = gen_en && h_last && v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      fpar <= 1'b0;
    end else if (!gen_en) begin
      hcnt <= '0;
      vcnt <= '0;
      fpar <= 1'b0;
    end else if (h_last) begin
      hcnt <= '0;
      if (v_last) begin
        vcnt <= '0;
        fpar <= ~fpar;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en && htot != '0 |-> hcnt < htot); // R2
  AST_V_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en && $past(gen_en) && hcnt != '0 |-> $stable(vcnt)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (hcnt == '0 && vcnt == '0)); // R9
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_en,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic          fpar,
  input  shape_t        shape,
  output logic [5:0]    sig_out,
  output logic          vb_rise,
  output logic          av_rise
);
  logic hb, hs, vb, vs, av, ach, chroma_line;
  logic vb_from, vb_until, vs_from, vs_until;
  logic vb_q, av_q;
  logic [5:0] act;

  always_comb begin
    hb = gen_en && (hcnt >= shape.act_px);
    hs = gen_en && (hcnt >= shape.hs_s) && (hcnt < shape.hs_e);
    vb_from  = (vcnt > shape.act_ln) || (vcnt == shape.act_ln && hcnt >= shape.vbh_s);
    vb_until = (vcnt == '0) && (hcnt < shape.vbh_e);
    vb = gen_en && (vb_from || vb_until);
    vs_from  = (vcnt > shape.vs_s) || (vcnt == shape.vs_s && hcnt >= shape.vsh_s);
    vs_until = (vcnt < shape.vs_e) || (vcnt == shape.vs_e && hcnt < shape.vsh_e);
    vs = gen_en && vs_from && vs_until;
    av = gen_en && !hb && !vb;
    unique case (shape.par)
      2'd0: chroma_line = !vcnt[0];
      2'd1: chroma_line = vcnt[0];
      2'd2: chroma_line = !vcnt[0] && !fpar;
      default: chroma_line = vcnt[0] && !fpar;
    endcase
    ach = av && chroma_line;
    act = {ach, av, hs, vs, hb, vb};
  end

  generate
    for (genvar g = 0; g < 6; g++) begin : g_pol
      assign sig_out[g] = shape.pol[g] ? act[g] : !act[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vb_q <= 1'b0;
      av_q <= 1'b0;
    end else begin
      vb_q <= vb;
      av_q <= av;
    end
  end

  assign vb_rise = vb && !vb_q;
  assign av_rise = av && !av_q;

  AST_CHROMA_WITHIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ach |-> !hb && !vb); // R7
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    addr,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          active_video,
  output logic          active_chroma,
  output logic          irq
);
  logic          gen_en, frame_wrap, vb_rise, av_rise, fpar;
  logic [CW-1:0] htot, vtot, hcnt, vcnt;
  logic [5:0]    sig;
  shape_t        shape;

  rtg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .frame_wrap(frame_wrap), .vb_rise(vb_rise), .av_rise(av_rise),
    .rd_data(rd_data), .gen_en(gen_en), .htot(htot), .vtot(vtot),
    .shape(shape), .irq(irq)
  );

  rtg_counters u_cnt (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .htot(htot), .vtot(vtot),
    .hcnt(hcnt), .vcnt(vcnt), .fpar(fpar), .frame_wrap(frame_wrap)
  );

  rtg_decode u_dec (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .hcnt(hcnt), .vcnt(vcnt),
    .fpar(fpar), .shape(shape), .sig_out(sig), .vb_rise(vb_rise), .av_rise(av_rise)
  );

  assign vblank        = sig[0];
  assign hblank        = sig[1];
  assign vsync         = sig[2];
  assign hsync         = sig[3];
  assign active_video  = sig[4];
  assign active_chroma = sig[5];

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (hsync == !shape.pol[3] && vsync == !shape.pol[2] && vblank == !shape.pol[0])); // R6
endmodule

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic hsync, vsync, hblank, vblank, active_video, active_chroma, irq;

  int checks = 0;
  int fails = 0;
  bit chk_on = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .hblank(hblank),
    .vblank(vblank), .active_video(active_video), .active_chroma(active_chroma),
    .irq(irq)
  );

  // reference state
  logic [31:0] sh [16];
  logic [31:0] wk [16];
  bit m_en, m_pend, m_vbq, m_avq;
  bit [1:0] m_st, m_ien;
  int h, v, f;

  function automatic int lo(logic [31:0] w); return int'(w[12:0]); endfunction
  function automatic int hi(logic [31:0] w); return int'(w[28:16]); endfunction

  function automatic logic [5:0] model_act();
    bit hb, hs, vb, vs, av, ach, cl;
    int par;
    if (!m_en) return 6'b0;
    hb = h >= lo(wk[5]);
    hs = h >= lo(wk[8]) && h < hi(wk[8]);
    vb = (v > hi(wk[5]) || (v == hi(wk[5]) && h >= lo(wk[11]))) || (v == 0 && h < hi(wk[11]));
    vs = (v > lo(wk[9]) || (v == lo(wk[9]) && h >= lo(wk[10]))) &&
         (v < hi(wk[9]) || (v == hi(wk[9]) && h < hi(wk[10])));
    av = !hb && !vb;
    par = int'(wk[4][9:8]);
    case (par)
      0: cl = (v % 2) == 0;
      1: cl = (v % 2) == 1;
      2: cl = (v % 2) == 0 && (f % 2) == 0;
      default: cl = (v % 2) == 1 && (f % 2) == 0;
    endcase
    ach = av && cl;
    return {ach, av, hs, vs, hb, vb};
  endfunction

  function automatic logic [5:0] model_out();
    return ~(model_act() ^ wk[3][5:0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin sh[i] = '0; wk[i] = '0; end
      sh[3] = 32'h3F; wk[3] = 32'h3F;
      m_en = 0; m_pend = 0; m_vbq = 0; m_avq = 0; m_st = 0; m_ien = 0;
      h = 0; v = 0; f = 0;
    end else begin
      logic [5:0] a;
      bit wrap, apply, commit;
      bit [1:0] clr, set;
      a = model_act();
      set = {a[4] && !m_avq, a[0] && !m_vbq};
      m_vbq = a[0]; m_avq = a[4];
      clr = (wr_en && addr == 4'd1) ? wr_data[13:12] : 2'b00;
      m_st = (m_st & ~clr) | set;
      wrap = m_en && (h + 1 >= lo(wk[6])) && (v + 1 >= lo(wk[7]));
      apply = m_pend && (!m_en || wrap);
      if (!m_en) begin h = 0; v = 0; f = 0; end
      else if (h + 1 >= lo(wk[6])) begin
        h = 0;
        if (v + 1 >= lo(wk[7])) begin v = 0; f = f + 1; end else v = v + 1;
      end else h = h + 1;
      commit = wr_en && addr == 4'd0 && wr_data[1];
      if (apply) for (int i = 3; i < 12; i++) wk[i] = sh[i];
      m_pend = (m_pend && !apply) || commit;
      if (wr_en && addr >= 4'd3 && addr <= 4'd11) sh[addr] = wr_data;
      if (wr_en && addr == 4'd0) m_en = wr_data[2];
      if (wr_en && addr == 4'd2) m_ien = wr_data[13:12];
    end
  end

  function automatic string tag_of(int b);
    case (b)
      0: return "R4 vblank";
      1: return "R3 hblank";
      2: return "R5 vsync";
      3: return "R3 hsync";
      4: return "R3 active_video";
      default: return "R7 active_chroma";
    endcase
  endfunction

  // continuous comparison against the reference (R2 counting underlies every compare)
  always @(negedge clk) begin
    if (chk_on) begin
      logic [5:0] got, exp;
      got = {active_chroma, active_video, hsync, vsync, hblank, vblank};
      exp = model_out();
      checks++;
      if (got !== exp || irq !== |(m_st & m_ien)) begin
        fails++;
        for (int b = 0; b < 6; b++)
          if (got[b] !== exp[b])
            $display("FAIL %s R2 at h=%0d v=%0d f=%0d: got %b exp %b", tag_of(b), h, v, f, got[b], exp[b]);
        if (irq !== |(m_st & m_ien))
          $display("FAIL R11 irq got %b exp %b", irq, |(m_st & m_ien));
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [1:0] st_snap);
    @(negedge clk);
    addr = a; st_snap = m_st;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic program_base();
    wr(4'd0, 32'h0);
    wr(4'd5, (32'd5 << 16) | 32'd6);
    wr(4'd6, 32'd10);
    wr(4'd7, 32'd8);
    wr(4'd8, (32'd9 << 16) | 32'd7);
    wr(4'd9, (32'd7 << 16) | 32'd6);
    wr(4'd10, 32'h0);
    wr(4'd11, 32'h0);
    wr(4'd3, 32'h3F);
    wr(4'd4, 32'h0);
    wr(4'd0, 32'h2);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [1:0] s;
    @(negedge clk);
    check("R1 outputs idle", {26'b0, active_chroma, active_video, hsync, vsync, hblank, vblank}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(4'd0, d, s); check("R1 ctrl reads 0", d, 32'h0);
    rd(4'd3, d, s); check("R1 polarity reads 3F", d, 32'h3F);
    rd(4'd14, d, s); check("R12 unused address", d, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d; logic [1:0] s;
    program_base();
    wr(4'd0, 32'h4);
    idle(250);
    rd(4'd5, d, s); check("R12 active size field layout", d, 32'h0005_0006);
    rd(4'd0, d, s); check("R2 run bit reads back", d, 32'h4);
  endtask

  task automatic t_offsets();
    wr(4'd0, 32'h0);
    wr(4'd11, (32'd4 << 16) | 32'd3);
    wr(4'd10, (32'd5 << 16) | 32'd2);
    wr(4'd0, 32'h2);
    idle(2);
    wr(4'd0, 32'h4);
    idle(250);
  endtask

  task automatic t_polarity();
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h2A);
    wr(4'd0, 32'h2);
    idle(2);
    @(negedge clk);
    check("R6 idle levels follow polarity",
          {26'b0, active_chroma, active_video, hsync, vsync, hblank, vblank}, 32'h15);
    wr(4'd0, 32'h4);
    idle(170);
    wr(4'd0, 32'h0);
    wr(4'd3, 32'h3F);
    wr(4'd0, 32'h2);
    idle(2);
  endtask

  task automatic t_chroma();
    for (int c = 0; c < 4; c++) begin
      wr(4'd0, 32'h0);
      wr(4'd4, 32'(c) << 8);
      wr(4'd0, 32'h2);
      idle(2);
      wr(4'd0, 32'h4);
      idle(250);
    end
  endtask

  task automatic t_shadow();
    logic [31:0] d; logic [1:0] s;
    wr(4'd6, 32'd12);
    wr(4'd3, 32'h00);
    idle(90);
    rd(4'd6, d, s); check("R8 readback returns shadow", d, 32'd12);
    wr(4'd0, 32'h6);
    idle(300);
    wr(4'd3, 32'h3F);
    wr(4'd0, 32'h6);
    idle(120);
  endtask

  task automatic t_disable();
    wr(4'd0, 32'h0);
    @(negedge clk);
    check("R9 outputs idle after stop",
          {26'b0, active_chroma, active_video, hsync, vsync, hblank, vblank}, 32'h0);
    idle(5);
    wr(4'd0, 32'h4);
    @(negedge clk);
    check("R9 restart at line 0 shows hblank low", {31'b0, hblank}, 32'h0);
    idle(100);
  endtask

  task automatic t_status();
    logic [31:0] d; logic [1:0] s;
    wr(4'd1, 32'h3000);
    wr(4'd2, 32'h3000);
    idle(130);
    @(negedge clk);
    check("R11 irq with enabled status", {31'b0, irq}, 32'h1);
    rd(4'd1, d, s);
    check("R10 both events captured", d, 32'h3000);
    check("R10 status matches reference", d, {18'b0, s, 12'b0});
    wr(4'd1, 32'h1000);
    rd(4'd1, d, s);
    check("R10 write-1 clears only bit 12", d, {18'b0, s, 12'b0});
    check("R10 bit 13 survives", d & 32'h2000, 32'h2000);
    wr(4'd2, 32'h0);
    @(negedge clk);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #0.1 chk_on = 1;
    t_reset();
    t_basic();
    t_offsets();
    t_polarity();
    t_chroma();
    t_shadow();
    t_disable();
    t_status();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule